// File: doc/BRIEF.md
# Supervisor Trap Entry and Return Register Unit

This unit keeps the supervisor-level trap state of a 32-bit core: a status word, the trap vector base, the saved exception pc, the cause code, the trap value and a one-bit current privilege (1 = supervisor, 0 = user). When the pipeline reports an exception, the unit updates every trap register in one clock edge. It also sends the pipeline a one-cycle redirect to the handler entry. An exception-return strobe unwinds the interrupt-enable stack and redirects to the saved pc.

Software reaches the registers through a small port. The read side is combinational and the write side takes effect on the clock edge. The vector register keeps all its bits, but the unit only implements direct mode: the two low bits are masked off whenever a redirect target is formed. Trap events take priority over software writes that arrive in the same cycle.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset, every mapped register reads 0, `priv_s` is 1 and `redir_valid` is 0.
- R2: The status word (address 0x100) stores SIE at bit 1, MIE at bit 3, SPIE at bit 5, MPIE at bit 7, SPP at bit 8 and MPP at bits 12:11. All other bits read 0, so writing all ones reads back 0x000019AA.
- R3: Status bit 6 (byte-order select) always reads 0, and writing it has no effect.
- R4: On an exception, SPIE takes the SIE value from before the trap, SIE becomes 0, SPP becomes 1 and `priv_s` becomes 1, all in the same edge. The trap is taken whatever the value of SIE.
- R5: On an exception, the cause register (0x142) receives `exc_cause` with bit 31 forced to 0. The trap-value register (0x143) receives `exc_tval`, and the saved-pc register (0x141) receives `exc_pc`.
- R6: One cycle after an exception, `redir_valid` is 1 and `redir_pc` equals the vector register (0x105) from before the trap with bits 1:0 cleared. `redir_valid` is 0 in any cycle that follows no trap and no return.
- R7: On a return strobe without an exception, SIE takes SPIE, SPIE becomes 1, SPP becomes 0 and `priv_s` takes the old SPP. One cycle later `redir_valid` is 1 and `redir_pc` is the saved pc with bits 1:0 cleared.
- R8: A read of any address other than 0x100, 0x105, 0x141, 0x142 or 0x143 returns 0, and a write to such an address changes no register.
- R9: If an exception or a return arrives in the same cycle as a software write, the write is dropped. If an exception and a return arrive together, only the exception is taken.
- R10: The vector register stores and reads back all 32 bits, including its two-bit mode field. The mode field never affects the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request this cycle |
| exc_cause | input | 32 | Exception cause code |
| exc_tval | input | 32 | Trap-specific value |
| exc_pc | input | 32 | Pc of the faulting instruction |
| sret_valid | input | 1 | Supervisor return strobe |
| csr_we | input | 1 | Software write enable |
| csr_addr | input | 12 | Software register address |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_pc | output | 32 | Redirect target |
| priv_s | output | 1 | Current privilege, 1 = supervisor |

## Verification
Every register update, including the privilege bit, is visible one edge after its stimulus. The redirect pulse and its target also appear one edge after the trap or return, while `csr_rdata` follows the address in the same cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge. Half a cycle later it compares read data, redirect and privilege, so each result is sampled in the first cycle it is due. Because the read compare uses the address that was held during the edge, a software write is checked in the cycle right after it lands.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    localparam int CSR_AW  = 12;
    localparam int NUM_CSR = 5;

    // index of each register in the decode and read vectors
    localparam int IDX_STATUS = 0;
    localparam int IDX_TVEC   = 1;
    localparam int IDX_EPC    = 2;
    localparam int IDX_CAUSE  = 3;
    localparam int IDX_TVAL   = 4;

    localparam logic [CSR_AW-1:0] CSR_ADDRS [NUM_CSR] =
        '{12'h100, 12'h105, 12'h141, 12'h142, 12'h143};

    // status word bit positions
    localparam int SIE_B  = 1;
    localparam int MIE_B  = 3;
    localparam int SPIE_B = 5;
    localparam int UBE_B  = 6;
    localparam int MPIE_B = 7;
    localparam int SPP_B  = 8;
    localparam int MPP_LO = 11;

    typedef struct packed {
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
    } stat_t;

endpackage

// File: rtl/trap_status_next.sv
module trap_status_next
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  stat_t            cur,
    input  logic             cur_priv,
    input  logic             take_trap,
    input  logic             take_ret,
    input  logic             wr_en,
    input  stat_t            wr_val,
    output stat_t            nxt,
    output logic             nxt_priv,
    output logic [XLEN-1:0]  rd_word
);

    always_comb begin
        nxt      = cur;
        nxt_priv = cur_priv;
        if (take_trap) begin
            // both fields derive from the pre-trap value
            nxt.spie = cur.sie;
            nxt.sie  = 1'b0;
            nxt.spp  = 1'b1;
            nxt_priv = 1'b1;
        end else if (take_ret) begin
            nxt.sie  = cur.spie;
            nxt.spie = 1'b1;
            nxt.spp  = 1'b0;
            nxt_priv = cur.spp;
        end else if (wr_en) begin
            nxt = wr_val;
        end
    end

    always_comb begin
        rd_word               = '0;
        rd_word[SIE_B]        = cur.sie;
        rd_word[MIE_B]        = cur.mie;
        rd_word[SPIE_B]       = cur.spie;
        rd_word[MPIE_B]       = cur.mpie;
        rd_word[SPP_B]        = cur.spp;
        rd_word[MPP_LO +: 2]  = cur.mpp;
    end

endmodule

// File: rtl/trap_csr_decode.sv
module trap_csr_decode
    import trap_csr_pkg::*;
(
    input  logic [CSR_AW-1:0]  addr,
    output logic [NUM_CSR-1:0] sel,
    output logic               hit
);

    for (genvar i = 0; i < NUM_CSR; i++) begin : g_cmp
        assign sel[i] = (addr == CSR_ADDRS[i]);
    end

    assign hit = |sel;

endmodule

// File: rtl/trap_redirect_sel.sv
module trap_redirect_sel #(
    parameter int XLEN = 32
) (
    input  logic            take_trap,
    input  logic            take_ret,
    input  logic [XLEN-3:0] tvec_base,
    input  logic [XLEN-3:0] epc_base,
    output logic            valid,
    output logic [XLEN-1:0] target
);

    always_comb begin
        valid  = take_trap | take_ret;
        target = '0;
        if (take_trap)
            target = {tvec_base, 2'b00};
        else if (take_ret)
            target = {epc_base, 2'b00};
    end

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [XLEN-1:0]    exc_cause,
    input  logic [XLEN-1:0]    exc_tval,
    input  logic [XLEN-1:0]    exc_pc,
    input  logic               sret_valid,
    input  logic               csr_we,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_pc,
    output logic               priv_s
);

    localparam logic [XLEN-1:0] CAUSE_KEEP = {1'b0, {(XLEN-1){1'b1}}};

    typedef struct packed {
        stat_t           st;
        logic            priv;
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic            rv;
        logic [XLEN-1:0] rpc;
    } regs_t;

    regs_t r_d, r_q;

    logic               take_trap, take_ret, wr_ok;
    logic [NUM_CSR-1:0] sel;
    logic               hit;
    stat_t              st_wr, st_nxt;
    logic               priv_nxt;
    logic [XLEN-1:0]    st_word;
    logic               rv_nxt;
    logic [XLEN-1:0]    rpc_nxt;
    logic [XLEN-1:0]    rd_words [NUM_CSR];

    assign take_trap = exc_valid;
    assign take_ret  = sret_valid & ~exc_valid;
    assign wr_ok     = csr_we & ~exc_valid & ~sret_valid;

    always_comb begin
        st_wr.sie  = csr_wdata[SIE_B];
        st_wr.mie  = csr_wdata[MIE_B];
        st_wr.spie = csr_wdata[SPIE_B];
        st_wr.mpie = csr_wdata[MPIE_B];
        st_wr.spp  = csr_wdata[SPP_B];
        st_wr.mpp  = csr_wdata[MPP_LO +: 2];
    end

    trap_csr_decode u_dec (
        .addr (csr_addr),
        .sel  (sel),
        .hit  (hit)
    );

    trap_status_next #(.XLEN(XLEN)) u_stat (
        .cur       (r_q.st),
        .cur_priv  (r_q.priv),
        .take_trap (take_trap),
        .take_ret  (take_ret),
        .wr_en     (wr_ok & sel[IDX_STATUS]),
        .wr_val    (st_wr),
        .nxt       (st_nxt),
        .nxt_priv  (priv_nxt),
        .rd_word   (st_word)
    );

    trap_redirect_sel #(.XLEN(XLEN)) u_redir (
        .take_trap (take_trap),
        .take_ret  (take_ret),
        .tvec_base (r_q.tvec[XLEN-1:2]),
        .epc_base  (r_q.epc[XLEN-1:2]),
        .valid     (rv_nxt),
        .target    (rpc_nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.st   = st_nxt;
        r_d.priv = priv_nxt;
        r_d.rv   = rv_nxt;
        r_d.rpc  = rv_nxt ? rpc_nxt : r_q.rpc;
        if (take_trap) begin
            r_d.cause = exc_cause & CAUSE_KEEP;
            r_d.tval  = exc_tval;
            r_d.epc   = exc_pc;
        end else if (wr_ok) begin
            if (sel[IDX_TVEC])  r_d.tvec  = csr_wdata;
            if (sel[IDX_EPC])   r_d.epc   = csr_wdata;
            if (sel[IDX_CAUSE]) r_d.cause = csr_wdata;
            if (sel[IDX_TVAL])  r_d.tval  = csr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.priv <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_words[IDX_STATUS] = st_word;
    assign rd_words[IDX_TVEC]   = r_q.tvec;
    assign rd_words[IDX_EPC]    = r_q.epc;
    assign rd_words[IDX_CAUSE]  = r_q.cause;
    assign rd_words[IDX_TVAL]   = r_q.tval;

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_CSR; i++)
            if (sel[i]) csr_rdata = csr_rdata | rd_words[i];
    end

    assign redir_valid = r_q.rv;
    assign redir_pc    = r_q.rpc;
    assign priv_s      = r_q.priv;

    // ---------------- assertions ----------------
    assert_ube_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CSR_ADDRS[IDX_STATUS]) |-> !csr_rdata[UBE_B]);

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (csr_rdata == '0));

    assert_trap_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (r_q.st.spie == $past(r_q.st.sie)) && !r_q.st.sie
                      && r_q.st.spp && priv_s);

    assert_trap_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !r_q.cause[XLEN-1] && (r_q.epc == $past(exc_pc))
                      && (r_q.tval == $past(exc_tval)));

    assert_trap_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> redir_valid
                      && (redir_pc == {$past(r_q.tvec[XLEN-1:2]), 2'b00}));

    assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_valid && !exc_valid) |=> (r_q.st.sie == $past(r_q.st.spie))
                      && r_q.st.spie && !r_q.st.spp
                      && (priv_s == $past(r_q.st.spp)));

    assert_drop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && csr_we && (csr_addr == CSR_ADDRS[IDX_TVEC]))
            |=> $stable(r_q.tvec));

endmodule

// File: tb/trap_csr_unit_test.sv
module trap_csr_unit_test;

    localparam logic [11:0] A_ST = 12'h100, A_TV = 12'h105, A_EP = 12'h141,
                            A_CA = 12'h142, A_VA = 12'h143, A_NO = 12'h180;

    logic        clk = 0, rst_n = 0;
    logic        exc_valid = 0, sret_valid = 0, csr_we = 0;
    logic [31:0] exc_cause = 0, exc_tval = 0, exc_pc = 0, csr_wdata = 0;
    logic [11:0] csr_addr = 0;
    logic [31:0] csr_rdata, redir_pc;
    logic        redir_valid, priv_s;

    int total = 0, bad = 0;

    // behavioural reference state
    bit        m_sie, m_mie, m_spie, m_mpie, m_spp, m_priv, m_rv;
    bit [1:0]  m_mpp;
    bit [31:0] m_tvec, m_epc, m_cause, m_tval, m_rpc;

    always #5 clk = ~clk;

    trap_csr_unit uut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_tval(exc_tval), .exc_pc(exc_pc), .sret_valid(sret_valid),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .priv_s(priv_s)
    );

    function automatic bit [31:0] m_read(bit [11:0] a);
        bit [31:0] w = 0;
        case (a)
            A_ST: begin
                w[1] = m_sie; w[3] = m_mie; w[5] = m_spie; w[7] = m_mpie;
                w[8] = m_spp; w[12:11] = m_mpp;
            end
            A_TV: w = m_tvec;
            A_EP: w = m_epc;
            A_CA: w = m_cause;
            A_VA: w = m_tval;
            default: w = 0;
        endcase
        return w;
    endfunction

    task automatic chk(string tag, string what, bit [31:0] act, bit [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_edge(bit e, bit [31:0] c, bit [31:0] tv, bit [31:0] pc,
                          bit s, bit we, bit [11:0] a, bit [31:0] wd);
        if (e) begin
            m_spie = m_sie; m_sie = 0; m_spp = 1; m_priv = 1;
            m_cause = c & 32'h7FFF_FFFF; m_tval = tv; m_epc = pc;
            m_rv = 1; m_rpc = m_tvec & ~32'h3;
        end else if (s) begin
            m_sie = m_spie; m_spie = 1; m_priv = m_spp; m_spp = 0;
            m_rv = 1; m_rpc = m_epc & ~32'h3;
        end else begin
            m_rv = 0;
            if (we) case (a)
                A_ST: begin
                    m_sie = wd[1]; m_mie = wd[3]; m_spie = wd[5]; m_mpie = wd[7];
                    m_spp = wd[8]; m_mpp = wd[12:11];
                end
                A_TV: m_tvec = wd;
                A_EP: m_epc = wd;
                A_CA: m_cause = wd;
                A_VA: m_tval = wd;
                default: ;
            endcase
        end
    endtask

    // one clock: drive on falling edge, compare half a cycle after the rising edge
    task automatic step(string tag, bit e, bit [31:0] c, bit [31:0] tv, bit [31:0] pc,
                        bit s, bit we, bit [11:0] a, bit [31:0] wd);
        exc_valid = e; exc_cause = c; exc_tval = tv; exc_pc = pc;
        sret_valid = s; csr_we = we; csr_addr = a; csr_wdata = wd;
        @(posedge clk);
        m_edge(e, c, tv, pc, s, we, a, wd);
        @(negedge clk);
        chk(tag, "rdata", csr_rdata, m_read(a));
        chk(tag, "redir_valid", {31'b0, redir_valid}, {31'b0, m_rv});
        if (m_rv) chk(tag, "redir_pc", redir_pc, m_rpc);
        chk(tag, "priv", {31'b0, priv_s}, {31'b0, m_priv});
    endtask

    task automatic rd(string tag, bit [11:0] a);
        step(tag, 0, 0, 0, 0, 0, 0, a, 0);
    endtask

    task automatic wr(string tag, bit [11:0] a, bit [31:0] d);
        step(tag, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_priv = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "reset status", csr_rdata, 32'h0);
        chk("R1", "reset priv", {31'b0, priv_s}, 32'h1);
        chk("R1", "reset redir", {31'b0, redir_valid}, 32'h0);
        rd("R1", A_ST); rd("R1", A_TV); rd("R1", A_EP); rd("R1", A_CA); rd("R1", A_VA);
        // R2 layout
        wr("R2", A_ST, 32'hFFFF_FFFF);
        rd("R2", A_ST);
        chk("R2", "all-ones status", csr_rdata, 32'h0000_19AA);
        // R3 byte-order bit
        wr("R3", A_ST, 32'h0000_0040);
        rd("R3", A_ST);
        chk("R3", "ube only", csr_rdata, 32'h0);
        wr("R2", A_ST, 32'h0000_0022);
        // R10 vector keeps mode bits
        wr("R10", A_TV, 32'h8000_0103);
        rd("R10", A_TV);
        // R4 R5 R6 trap with SIE set
        step("R4", 1, 32'h8000_0005, 32'h0000_DEAD, 32'h0000_1000, 0, 0, A_ST, 0);
        chk("R6", "trap target", redir_pc, 32'h8000_0100);
        chk("R4", "status after trap", csr_rdata, 32'h0000_0120);
        rd("R6", A_CA);
        chk("R5", "cause msb cleared", csr_rdata, 32'h0000_0005);
        rd("R5", A_VA); rd("R5", A_EP);
        // R9 trap with simultaneous write; R4 trap with SIE clear
        step("R9", 1, 32'h2, 32'h44, 32'h2000, 0, 1, A_TV, 32'h0);
        rd("R9", A_TV);
        chk("R10", "vector unchanged", csr_rdata, 32'h8000_0103);
        rd("R4", A_ST);
        // R7 returns
        wr("R7", A_EP, 32'h0000_2007);
        step("R7", 0, 0, 0, 0, 1, 0, A_ST, 0);
        chk("R7", "return target", redir_pc, 32'h0000_2004);
        step("R7", 0, 0, 0, 0, 1, 0, A_ST, 0);
        chk("R7", "priv to user", {31'b0, priv_s}, 32'h0);
        // R4 trap from user with SIE=1
        step("R4", 1, 32'h8, 32'h0, 32'h3000, 0, 0, A_ST, 0);
        // R8 unmapped
        wr("R8", A_NO, 32'hFFFF_FFFF);
        rd("R8", A_NO);
        rd("R8", A_ST); rd("R8", A_EP); rd("R8", A_CA); rd("R8", A_VA); rd("R8", A_TV);
        // R9 return with write, trap with return
        step("R9", 0, 0, 0, 0, 1, 1, A_ST, 32'h0000_1800);
        rd("R9", A_ST);
        step("R9", 1, 32'hC, 32'h55, 32'h4004, 1, 0, A_ST, 0);
        chk("R9", "trap beats return", redir_pc, 32'h8000_0100);
        rd("R9", A_EP);
        // R6 no redirect when idle
        rd("R6", A_ST);
        chk("R6", "idle redirect", {31'b0, redir_valid}, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule